// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It runs an external analog front end through a loop of four phases: auto zero, input integration, reference deintegration and integrator zero. It selects each phase with a two-bit code on a pair of select outputs. The integration window is a fixed number of clocks. The same counter then restarts and measures the deintegration time. That measurement ends when the front end's comparator falls, which means the integrator has returned to its starting level.

The comparator level seen at the close of integration gives the sign of the input. Because the reference applied during deintegration has the opposite polarity, the result is a sign bit plus the deintegration count. The input voltage is the reference times the count divided by the integration length, with the sign taken from the sign bit. Each finished result comes with a one-cycle valid strobe. If the comparator never falls, a timeout saturates the count, raises an over-range flag and keeps the loop running.

All phase lengths and the timeout are parameters, so the block can run from slower or faster clocks. The defaults suit a 1.8432 MHz clock: 123,093 clocks each for auto zero and integration, 1,843 clocks for integrator zero, and a timeout of 262,143.

Top module: `dsadc_seq`

## Requirements
- R1: While `rst` is high, the phase code `{phase_a, phase_b}` is 2'b01 (auto zero), `result_valid` is 0, and `result_mag`, `result_neg` and `over_range` are 0.
- R2: The phase code follows the fixed order auto zero (01), integrate (10), deintegrate (11), integrator zero (00), and then returns to auto zero. No other transition ever occurs.
- R3: Auto zero lasts exactly AZ_CYCLES clocks, integrate lasts exactly INT_CYCLES clocks and integrator zero lasts exactly IZ_CYCLES clocks. This includes the first auto zero after reset is released.
- R4: `comp_in` passes through two synchroniser flops before a falling edge is detected. If `comp_in` goes low while the deintegrate count is D, the latched magnitude is D+2. Deintegration then lasts magnitude+1 clocks.
- R5: `result_neg` is 1 when the synchronised comparator is low in the last integrate clock (negative input), and 0 when it is high.
- R6: If no falling edge is detected by the time the count reaches DEINT_LIMIT, the magnitude saturates at DEINT_LIMIT and `over_range` is 1. Deintegration then lasts DEINT_LIMIT+1 clocks and the sequence moves on to integrator zero. A falling edge detected at exactly DEINT_LIMIT counts as a normal result with `over_range` 0.
- R7: `result_valid` is high for exactly the first clock of integrator zero. `result_mag`, `result_neg` and `over_range` change only together with it and hold their values until the next result.
- R8: Comparator edges during auto zero and integrator zero have no effect: they do not change the phase lengths and produce no result.
- R9: A rising comparator edge during deintegration does not end the phase; only a falling edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_in | input | 1 | Asynchronous comparator output from the front end |
| phase_a | output | 1 | Phase code, upper bit |
| phase_b | output | 1 | Phase code, lower bit |
| result_valid | output | 1 | One-cycle strobe for a new result |
| result_neg | output | 1 | Sign of the input, 1 = negative |
| result_mag | output | CNT_W | Deintegration count (magnitude) |
| over_range | output | 1 | Count saturated by timeout |

## Verification
A drop on `comp_in` reaches the falling-edge detector two clocks later. The magnitude and the phase change to integrator zero appear on the clock edge after that. The bench therefore expects a magnitude of D+2 for a drop applied at count D, and a deintegration phase of magnitude+1 clocks. The bench drives inputs and samples outputs on the falling clock edge. It measures each phase as the number of consecutive samples showing the same code. It expects the valid strobe and the new result on the first sample of integrator zero, and it expects the strobe to be gone on the next sample.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    // Phase code as driven on {phase_a, phase_b}
    typedef enum logic [1:0] {
        PH_IZERO = 2'b00,
        PH_AZERO = 2'b01,
        PH_INTEG = 2'b10,
        PH_DEINT = 2'b11
    } phase_e;

    typedef struct packed {
        logic neg;
        logic over;
    } res_flags_t;

    function automatic phase_e phase_after(phase_e cur);
        case (cur)
            PH_AZERO: return PH_INTEG;
            PH_INTEG: return PH_DEINT;
            PH_DEINT: return PH_IZERO;
            default:  return PH_AZERO;
        endcase
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic fell
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign fell  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
    import dsadc_pkg::*;
#(
    parameter int AZ_CYCLES   = 123093,
    parameter int INT_CYCLES  = 123093,
    parameter int IZ_CYCLES   = 1843,
    parameter int DEINT_LIMIT = 262143,
    parameter int CNT_W       = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fell,
    output phase_e           phase,
    output logic [CNT_W-1:0] count,
    output logic             int_last,
    output logic             deint_end,
    output logic             timed_out
);
    localparam logic [CNT_W-1:0] AZ_LAST  = CNT_W'(AZ_CYCLES - 1);
    localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INT_CYCLES - 1);
    localparam logic [CNT_W-1:0] IZ_LAST  = CNT_W'(IZ_CYCLES - 1);
    localparam logic [CNT_W-1:0] LIM      = CNT_W'(DEINT_LIMIT);

    logic at_limit;
    logic leave;

    always_comb begin
        at_limit  = (count == LIM);
        int_last  = (phase == PH_INTEG) && (count == INT_LAST);
        deint_end = (phase == PH_DEINT) && (fell || at_limit);
        timed_out = deint_end && !fell;
        case (phase)
            PH_AZERO: leave = (count == AZ_LAST);
            PH_INTEG: leave = int_last;
            PH_DEINT: leave = deint_end;
            default:  leave = (count == IZ_LAST);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_AZERO;
            count <= '0;
        end else if (leave) begin
            phase <= phase_after(phase);
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dsadc_result.sv
module dsadc_result
    import dsadc_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             int_last,
    input  logic             comp_level,
    input  logic             deint_end,
    input  logic             timed_out,
    input  logic [CNT_W-1:0] count,
    output logic             valid,
    output res_flags_t       flags,
    output logic [CNT_W-1:0] mag
);
    logic sign_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            sign_hold <= 1'b0;
            valid     <= 1'b0;
            flags     <= '0;
            mag       <= '0;
        end else begin
            if (int_last) sign_hold <= ~comp_level;
            valid <= deint_end;
            if (deint_end) begin
                mag        <= count;
                flags.neg  <= sign_hold;
                flags.over <= timed_out;
            end
        end
    end
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int  AZ_CYCLES   = 123093,
    parameter int  INT_CYCLES  = 123093,
    parameter int  IZ_CYCLES   = 1843,
    parameter int  DEINT_LIMIT = 262143,
    localparam int CNT_MAX     = max4(AZ_CYCLES - 1, INT_CYCLES - 1, IZ_CYCLES - 1, DEINT_LIMIT),
    localparam int CNT_W       = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             comp_in,
    output logic             phase_a,
    output logic             phase_b,
    output logic             result_valid,
    output logic             result_neg,
    output logic [CNT_W-1:0] result_mag,
    output logic             over_range
);
    logic             comp_level;
    logic             comp_fell;
    phase_e           phase;
    logic [CNT_W-1:0] count;
    logic             int_last;
    logic             deint_end;
    logic             timed_out;
    res_flags_t       flags;

    dsadc_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (comp_in),
        .level    (comp_level),
        .fell     (comp_fell)
    );

    dsadc_phase_ctrl #(
        .AZ_CYCLES   (AZ_CYCLES),
        .INT_CYCLES  (INT_CYCLES),
        .IZ_CYCLES   (IZ_CYCLES),
        .DEINT_LIMIT (DEINT_LIMIT),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .fell      (comp_fell),
        .phase     (phase),
        .count     (count),
        .int_last  (int_last),
        .deint_end (deint_end),
        .timed_out (timed_out)
    );

    dsadc_result #(.CNT_W(CNT_W)) u_res (
        .clk        (clk),
        .rst        (rst),
        .int_last   (int_last),
        .comp_level (comp_level),
        .deint_end  (deint_end),
        .timed_out  (timed_out),
        .count      (count),
        .valid      (result_valid),
        .flags      (flags),
        .mag        (result_mag)
    );

    assign phase_a    = phase[1];
    assign phase_b    = phase[0];
    assign result_neg = flags.neg;
    assign over_range = flags.over;
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
    parameter int LIMIT = 262143,
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             phase_a,
    input logic             phase_b,
    input logic             result_valid,
    input logic             result_neg,
    input logic [CNT_W-1:0] result_mag,
    input logic             over_range
);
    logic [1:0] ph;
    logic [1:0] ph_next;
    assign ph = {phase_a, phase_b};
    always_comb begin
        case (ph)
            2'b01:   ph_next = 2'b10;
            2'b10:   ph_next = 2'b11;
            2'b11:   ph_next = 2'b00;
            default: ph_next = 2'b01;
        endcase
    end

    // R2: only legal successors
    p_order_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ph == $past(ph)) || (ph == $past(ph_next)));

    // R7: strobe lasts one cycle
    p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R7: strobe only on entry to integrator zero
    p_entry_r7: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (ph == 2'b00) && ($past(ph) == 2'b11));

    // R7: result fields hold between strobes
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result_mag) && $stable(result_neg) && $stable(over_range));

    // R6: magnitude never passes the limit
    p_bound_r6: assert property (@(posedge clk) disable iff (rst)
        result_mag <= CNT_W'(LIMIT));

    // R6: over-range implies a saturated count
    p_sat_r6: assert property (@(posedge clk) disable iff (rst)
        over_range |-> result_mag == CNT_W'(LIMIT));
endmodule

bind dsadc_seq dsadc_seq_chk #(.LIMIT(DEINT_LIMIT), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .phase_a      (phase_a),
    .phase_b      (phase_b),
    .result_valid (result_valid),
    .result_neg   (result_neg),
    .result_mag   (result_mag),
    .over_range   (over_range)
);

// File: tb/dsadc_seq_bench.sv
module dsadc_seq_bench;
    localparam int B_AZ  = 20;
    localparam int B_INT = 16;
    localparam int B_IZ  = 8;
    localparam int B_LIM = 60;
    localparam int MW    = $clog2(B_LIM + 1);
    localparam int NCONV = 300;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          comp_in = 1'b0;
    logic          phase_a, phase_b, result_valid, result_neg, over_range;
    logic [MW-1:0] result_mag;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    dsadc_seq #(
        .AZ_CYCLES   (B_AZ),
        .INT_CYCLES  (B_INT),
        .IZ_CYCLES   (B_IZ),
        .DEINT_LIMIT (B_LIM)
    ) u_dsadc_seq (
        .clk          (clk),
        .rst          (rst),
        .comp_in      (comp_in),
        .phase_a      (phase_a),
        .phase_b      (phase_b),
        .result_valid (result_valid),
        .result_neg   (result_neg),
        .result_mag   (result_mag),
        .over_range   (over_range)
    );

    function automatic logic [1:0] ph();
        return {phase_a, phase_b};
    endfunction

    function automatic int exp_mag(int d);
        return (d + 2 <= B_LIM) ? d + 2 : B_LIM;
    endfunction

    function automatic bit exp_over(int d);
        return (d + 2 > B_LIM);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int d;
        bit pos;
        logic [MW-1:0] held;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ph() == 2'b01, "R1", "phase", ph(), 1);
        chk(!result_valid && result_mag == 0 && !result_neg && !over_range,
            "R1", "outputs", {result_valid, result_neg, over_range}, 0);
        rst = 1'b0;
        for (int c = 0; c < NCONV; c++) begin
            case (c)
                0:       begin pos = 1'b1; d = 1;         end
                1:       begin pos = 1'b0; d = 1;         end
                2:       begin pos = 1'b1; d = B_LIM - 2; end
                3:       begin pos = 1'b0; d = B_LIM - 1; end
                4:       begin pos = 1'b1; d = B_LIM + 3; end
                default: begin pos = $urandom % 2; d = 1 + ($urandom % (B_LIM + 4)); end
            endcase
            // auto zero with stray edges (R8)
            n = 0;
            while (ph() == 2'b01) begin
                n++;
                if (n == 2) comp_in = 1'b1;
                if (n == 4) comp_in = 1'b0;
                if (n == 6) comp_in = pos;
                @(negedge clk);
            end
            chk(n == B_AZ, "R3", "auto zero length (R8)", n, B_AZ);
            chk(ph() == 2'b10, "R2", "phase after auto zero", ph(), 2);
            n = 0;
            while (ph() == 2'b10) begin
                n++;
                @(negedge clk);
            end
            chk(n == B_INT, "R3", "integrate length", n, B_INT);
            chk(ph() == 2'b11, "R2", "phase after integrate", ph(), 3);
            // deintegrate: a rise first (R9), then a drop at count d
            comp_in = 1'b1;
            n = 1;
            for (int i = 1; i < B_LIM + 10; i++) begin
                @(negedge clk);
                if (ph() != 2'b11) break;
                n++;
                if (i == d) comp_in = 1'b0;
            end
            chk(n == exp_mag(d) + 1, exp_over(d) ? "R6" : "R4", "deintegrate length (R9)",
                n, exp_mag(d) + 1);
            chk(ph() == 2'b00, "R2", "phase after deintegrate", ph(), 0);
            chk(result_valid, "R7", "valid on entry", result_valid, 1);
            chk(int'(result_mag) == exp_mag(d), exp_over(d) ? "R6" : "R4", "magnitude",
                result_mag, exp_mag(d));
            chk(over_range == exp_over(d), "R6", "over_range", over_range, exp_over(d));
            chk(result_neg == !pos, "R5", "sign", result_neg, !pos);
            // integrator zero with a stray drop (R8)
            held = result_mag;
            comp_in = 1'b1;
            n = 1;
            forever begin
                @(negedge clk);
                if (ph() != 2'b00) break;
                n++;
                if (n == 2) chk(!result_valid, "R7", "valid single cycle", result_valid, 0);
                if (n == 3) comp_in = 1'b0;
            end
            chk(result_mag == held, "R7", "result held", result_mag, held);
            chk(n == B_IZ, "R3", "integrator zero length (R8)", n, B_IZ);
            chk(ph() == 2'b01, "R2", "phase after integrator zero", ph(), 1);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule